// File: doc/BRIEF.md
# Board Interrupt Aggregator Register Block

This block gathers sixteen external interrupt lines from a board and presents them to a host as one combined interrupt request. Each line passes through a two-flop synchronizer. A rising edge on a line sets its bit in a pending register, but only if that line's enable bit is set when the edge arrives. The host interrupt output is raised while any pending bit has its enable bit set. Software reads the pending register to find the source. It clears bits by writing the whole register back with those bits at zero.

The block also holds two card-socket words and eight plain 32-bit registers. The plain registers are storage for LED patterns, LED control, switch state and miscellaneous control; the block gives them no meaning. In each socket word only the five low control bits are writable. A ready flag in each socket word is always one. A card-detect bit in each socket word is the inverted, synchronized level of one interrupt line.

Access goes through a simple 32-bit register bus. It has a one-cycle write strobe and a registered read. Read data appears one clock after the read strobe and holds until the next read.

Top module: `board_irq_regs`

## Requirements
- R1: After reset, all plain registers, the enable register and the pending register read 0. Both socket words read 0x00000420 (bit 10 and bit 5 set). The host interrupt is low.
- R2: The plain registers at byte offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 each store and return all 32 written bits.
- R3: A write to the enable register (0xC0) or the pending register (0xD0) stores the written value ANDed with 0x000FEEFF. Lines 8 and 12 can therefore never be enabled.
- R4: A pending bit is set when its synchronized line goes from 0 to 1 and its enable bit is 1 at that moment. The bit is set at the third rising clock edge after the line changes. A line that is already high when it gets enabled sets nothing.
- R5: Lowering a line leaves its pending bit set. A write to the pending register replaces its whole content, so writing 0 to a bit clears it.
- R6: The host interrupt is high exactly while the AND of the pending and enable registers is nonzero. It follows every register change in the same cycle.
- R7: A write to a socket word (0xE0 for socket 0, 0xE4 for socket 1) changes only bits 4:0. Bit 10 stays 1 and all other bits keep their values.
- R8: Socket 0 bit 5 is the inverse of line 9 and socket 1 bit 5 is the inverse of line 13, each taken after the synchronizer. A high line reads as 0 and a low line reads as 1.
- R9: A read from any other offset returns 0. A write to any other offset changes no register.
- R10: Read data is captured at the clock edge where the read strobe is high. It holds its value while the strobe is low.
- R11: If a rising edge and a pending-register write land on the same clock edge, the register takes the written value with the newly latched bit ORed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe, data valid the next cycle |
| addr | input | 8 | Byte offset of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| irqIn | input | 16 | External interrupt lines, asynchronous |
| hostIrq | output | 1 | Combined interrupt to the host |

## Verification
The interrupt path is driven with several patterns:
- Lines rising while their enable bit is set, which must latch.
- A line rising while its enable bit is clear, and a line enabled only after it is already high. Neither may latch, which tells edge capture apart from level capture.
- Lines 8 and 12 rising with every enable bit written, which shows the write mask is applied.
- A rising edge timed to land on the same edge as a clearing write, which separates OR-in from write priority.

Toggling lines 9 and 13 against socket-word reads shows the card-detect inversion and its synchronizer delay. Writing all ones to the socket words shows that only the control field moves. Unmapped and misaligned offsets are accessed between writes to mapped registers, and the mapped registers are read back afterwards to confirm nothing changed.

// File: rtl/board_irq_pkg.sv
package board_irq_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int IRQ_N   = 16;
  localparam int GEN_N   = 8;
  localparam int SOCK_N  = 2;
  localparam int CTL_W   = 5;
  localparam int GEN_IW  = $clog2(GEN_N);
  localparam int READY_BIT = 10;
  localparam int DET_BIT   = 5;

  localparam logic [DATA_W-1:0] IRQ_KEEP = 32'h000F_EEFF;

  localparam logic [ADDR_W-1:0] GEN_OFS [GEN_N] =
    '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90};
  localparam logic [ADDR_W-1:0] OFS_ENA  = 8'hC0;
  localparam logic [ADDR_W-1:0] OFS_PEND = 8'hD0;
  localparam logic [ADDR_W-1:0] SOCK_OFS [SOCK_N] = '{8'hE0, 8'hE4};
  localparam int SOCK_SRC [SOCK_N] = '{9, 13};

  typedef enum logic [2:0] {
    SEL_NONE, SEL_GEN, SEL_ENA, SEL_PEND, SEL_SOCK
  } selKind_e;

  typedef struct packed {
    logic [GEN_N-1:0]  wrGen;
    logic              wrEna;
    logic              wrPend;
    logic [SOCK_N-1:0] wrSock;
    logic              rdEn;
    selKind_e          rdKind;
    logic [GEN_IW-1:0] rdIdx;
  } strobe_t;

  function automatic logic [DATA_W-1:0] sockWordOf(input logic [CTL_W-1:0] ctl,
                                                   input logic lineLvl);
    logic [DATA_W-1:0] w;
    w = '0;
    w[READY_BIT]  = 1'b1;
    w[DET_BIT]    = ~lineLvl;
    w[CTL_W-1:0]  = ctl;
    return w;
  endfunction
endpackage

// File: rtl/board_irq_ctrl.sv
module board_irq_ctrl
  import board_irq_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           st
);
  always_comb begin
    st        = '0;
    st.rdEn   = rdEn;
    st.rdKind = SEL_NONE;
    for (int i = 0; i < GEN_N; i++) begin
      if (addr == GEN_OFS[i]) begin
        st.wrGen[i] = wrEn;
        st.rdKind   = SEL_GEN;
        st.rdIdx    = GEN_IW'(i);
      end
    end
    if (addr == OFS_ENA) begin
      st.wrEna  = wrEn;
      st.rdKind = SEL_ENA;
    end
    if (addr == OFS_PEND) begin
      st.wrPend = wrEn;
      st.rdKind = SEL_PEND;
    end
    for (int i = 0; i < SOCK_N; i++) begin
      if (addr == SOCK_OFS[i]) begin
        st.wrSock[i] = wrEn;
        st.rdKind    = SEL_SOCK;
        st.rdIdx     = GEN_IW'(i);
      end
    end
  end

  // R9
  always_comb begin
    one_target_chk: assert ($onehot0({st.wrGen, st.wrEna, st.wrPend, st.wrSock}))
      else $error("write strobe hits more than one register");
  end
endmodule

// File: rtl/board_irq_dp.sv
module board_irq_dp
  import board_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IRQ_N-1:0]  irqIn,
  output logic [DATA_W-1:0] rdData,
  output logic              hostIrq
);
  logic [DATA_W-1:0] genReg [GEN_N];
  logic [CTL_W-1:0]  sockCtl [SOCK_N];
  logic [DATA_W-1:0] sockWord [SOCK_N];
  logic [IRQ_N-1:0]  irqS1, irqS2, irqPrev, rise;
  logic [DATA_W-1:0] riseW, enaReg, pendReg, rdMux;

  for (genvar g = 0; g < GEN_N; g++) begin : gGen
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            genReg[g] <= '0;
      else if (st.wrGen[g]) genReg[g] <= wrData;
    end
  end

  for (genvar s = 0; s < SOCK_N; s++) begin : gSock
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             sockCtl[s] <= '0;
      else if (st.wrSock[s]) sockCtl[s] <= wrData[CTL_W-1:0];
    end
    assign sockWord[s] = sockWordOf(sockCtl[s], irqS2[SOCK_SRC[s]]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqS1   <= '0;
      irqS2   <= '0;
      irqPrev <= '0;
    end else begin
      irqS1   <= irqIn;
      irqS2   <= irqS1;
      irqPrev <= irqS2;
    end
  end

  assign rise  = irqS2 & ~irqPrev;
  assign riseW = DATA_W'(rise);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enaReg  <= '0;
      pendReg <= '0;
    end else begin
      if (st.wrEna) enaReg <= wrData & IRQ_KEEP;
      pendReg <= (st.wrPend ? (wrData & IRQ_KEEP) : pendReg) | (riseW & enaReg);
    end
  end

  assign hostIrq = |(pendReg & enaReg);

  always_comb begin
    rdMux = '0;
    case (st.rdKind)
      SEL_GEN:  rdMux = genReg[st.rdIdx];
      SEL_ENA:  rdMux = enaReg;
      SEL_PEND: rdMux = pendReg;
      SEL_SOCK: begin
        for (int i = 0; i < SOCK_N; i++)
          if (int'(st.rdIdx) == i) rdMux = sockWord[i];
      end
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rdData <= '0;
    else if (st.rdEn) rdData <= rdMux;
  end

  // R3
  ena_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.wrEna |=> (enaReg == ($past(wrData) & IRQ_KEEP)))
    else $error("enable register not masked");

  // R4
  pend_needs_ena_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.wrPend |=> ((pendReg & ~$past(pendReg) & ~$past(enaReg)) == '0))
    else $error("pending bit set while disabled");

  // R5
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.wrPend |=> ((pendReg & $past(pendReg)) == $past(pendReg)))
    else $error("pending bit cleared without write");

  // R6
  host_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostIrq) |-> ($past(st.wrEna) || $past(st.wrPend) || $past(|rise)))
    else $error("host interrupt rose without cause");

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.rdEn |=> $stable(rdData))
    else $error("read data changed without read strobe");
endmodule

// File: rtl/board_irq_regs.sv
module board_irq_regs
  import board_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [IRQ_N-1:0]  irqIn,
  output logic              hostIrq
);
  strobe_t st;

  board_irq_ctrl i_ctrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .st   (st)
  );

  board_irq_dp i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .wrData  (wrData),
    .irqIn   (irqIn),
    .rdData  (rdData),
    .hostIrq (hostIrq)
  );
endmodule

// File: tb/test_board_irq_regs.sv
module test_board_irq_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [15:0] irqIn = '0;
  logic        hostIrq;

  int nChk = 0, nFail = 0;
  bit finished = 0;

  board_irq_regs i_board_irq_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqIn(irqIn), .hostIrq(hostIrq)
  );

  always #4 clk = ~clk;

  // reference model
  logic [31:0] mGen [8];
  logic [31:0] mEna, mPend, mRd;
  logic [4:0]  mCtl [2];
  logic [15:0] hist [$];
  bit          rdSeen;
  string       curTag = "R1", rdTag = "R1";

  function automatic int genIdx(input logic [7:0] a);
    case (a)
      8'h10: return 0;  8'h14: return 1;  8'h40: return 2;  8'h60: return 3;
      8'h80: return 4;  8'h84: return 5;  8'h88: return 6;  8'h90: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] sockModel(input int s);
    logic lvl;
    lvl = (s == 0) ? hist[1][9] : hist[1][13];
    return 32'h400 | ({31'b0, ~lvl} << 5) | {27'b0, mCtl[s]};
  endfunction

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    if (genIdx(a) >= 0) return mGen[genIdx(a)];
    case (a)
      8'hC0: return mEna;
      8'hD0: return mPend;
      8'hE0: return sockModel(0);
      8'hE4: return sockModel(1);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) mGen[i] = '0;
      mEna = '0; mPend = '0; mRd = '0; mCtl[0] = '0; mCtl[1] = '0;
      hist = '{16'h0, 16'h0, 16'h0};
      rdSeen = 0;
    end else begin
      logic [15:0] rise;
      logic [31:0] nPend;
      rdSeen = rdEn;
      if (rdEn) begin mRd = modelRead(addr); rdTag = curTag; end
      rise  = hist[1] & ~hist[2];
      nPend = (wrEn && addr == 8'hD0) ? (wrData & 32'hFEEFF) : mPend;
      nPend = nPend | {16'h0, rise & mEna[15:0]};
      if (wrEn) begin
        if (genIdx(addr) >= 0) mGen[genIdx(addr)] = wrData;
        if (addr == 8'hC0) mEna = wrData & 32'hFEEFF;
        if (addr == 8'hE0) mCtl[0] = wrData[4:0];
        if (addr == 8'hE4) mCtl[1] = wrData[4:0];
      end
      mPend = nPend;
      hist.push_front(irqIn);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(hostIrq == |(mPend & mEna), "R6", {31'b0, hostIrq}, {31'b0, |(mPend & mEna)});
      chk(rdData == mRd, rdSeen ? rdTag : "R10", rdData, mRd);
    end
  end

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, input string tag);
    @(negedge clk); rdEn = 1'b1; addr = a; curTag = tag;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic setIrq(input logic [15:0] v);
    @(negedge clk); irqIn = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    finished = 1;
    $display("  %0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    logic [7:0] genOfs [8];
    genOfs = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90};
    idle(4);
    chk(hostIrq == 1'b0 && rdData == 32'h0, "R1", rdData, 32'h0);
    rstN = 1'b1;
    // R1: reset values
    foreach (genOfs[i]) doRead(genOfs[i], "R1");
    doRead(8'hC0, "R1"); doRead(8'hD0, "R1");
    doRead(8'hE0, "R1");
    chk(rdData == 32'h420, "R1", rdData, 32'h420);
    doRead(8'hE4, "R1");
    // R2: plain registers
    foreach (genOfs[i]) doWrite(genOfs[i], 32'hA5000000 ^ (32'h01010101 * (i + 1)));
    foreach (genOfs[i]) doRead(genOfs[i], "R2");
    doWrite(8'h90, 32'hFFFF_FFFF); doRead(8'h90, "R2");
    // R3: masked enable and pending writes
    doWrite(8'hC0, 32'hFFFF_FFFF); doRead(8'hC0, "R3");
    chk(rdData == 32'h000FEEFF, "R3", rdData, 32'h000FEEFF);
    doWrite(8'hD0, 32'hFFFF_FFFF); doRead(8'hD0, "R3");
    // R5: clear by write
    doWrite(8'hD0, 32'h0); doRead(8'hD0, "R5");
    // R3 lines 8 and 12 cannot latch
    setIrq(16'h1100); idle(5); doRead(8'hD0, "R3");
    chk(rdData == 32'h0, "R3", rdData, 32'h0);
    setIrq(16'h0000); idle(4);
    // R4: enabled edges latch, disabled edge does not
    doWrite(8'hC0, 32'h0000_0009);
    setIrq(16'h000B); idle(5); doRead(8'hD0, "R4");
    chk(rdData == 32'h9, "R4", rdData, 32'h9);
    // R5: lowering does not clear
    setIrq(16'h0000); idle(5); doRead(8'hD0, "R5");
    // R4: enable after line already high latches nothing
    doWrite(8'hD0, 32'h0);
    setIrq(16'h0004); idle(5);
    doWrite(8'hC0, 32'h0000_000D); idle(5); doRead(8'hD0, "R4");
    chk(rdData == 32'h0, "R4", rdData, 32'h0);
    setIrq(16'h0000); idle(4);
    // R6: pending written while disabled, then enabled
    doWrite(8'hC0, 32'h0); doWrite(8'hD0, 32'h0000_0040); idle(2);
    doWrite(8'hC0, 32'h0000_0040); idle(2);
    chk(hostIrq == 1'b1, "R6", {31'b0, hostIrq}, 32'h1);
    doWrite(8'hD0, 32'h0); idle(2);
    // R11: edge coincides with clearing write
    doWrite(8'hC0, 32'h0000_0002);
    setIrq(16'h0002); @(negedge clk);
    doWrite(8'hD0, 32'h0); doRead(8'hD0, "R11");
    chk(rdData == 32'h2, "R11", rdData, 32'h2);
    setIrq(16'h0000); doWrite(8'hD0, 32'h0); idle(4);
    // R7: socket writes limited to low field
    doWrite(8'hE0, 32'hFFFF_FFFF); doRead(8'hE0, "R7");
    chk(rdData == 32'h43F, "R7", rdData, 32'h43F);
    doWrite(8'hE4, 32'h0000_0015); doRead(8'hE4, "R7");
    // R8: card detect follows lines 9 and 13
    setIrq(16'h0200); idle(3); doRead(8'hE0, "R8"); doRead(8'hE4, "R8");
    setIrq(16'h2000); idle(3); doRead(8'hE0, "R8"); doRead(8'hE4, "R8");
    chk(rdData == 32'h415, "R8", rdData, 32'h415);
    setIrq(16'h0000); idle(3); doRead(8'hE4, "R8");
    // R9: unmapped offsets
    doRead(8'h20, "R9"); doRead(8'h11, "R9"); doRead(8'hFC, "R9");
    chk(rdData == 32'h0, "R9", rdData, 32'h0);
    doWrite(8'h20, 32'hDEAD_BEEF); doWrite(8'h42, 32'h1234_5678); doWrite(8'hC4, 32'hFFFF_FFFF);
    foreach (genOfs[i]) doRead(genOfs[i], "R9");
    doRead(8'hC0, "R9"); doRead(8'hD0, "R9"); doRead(8'h20, "R9");
    // R10: hold between reads
    doRead(8'h14, "R10"); idle(6);
    summary();
  end
endmodule